// File: doc/BRIEF.md
# Two-Wire Bus Channel Connection Controller

This block is the digital control core of a four-channel multiplexer for a two-wire serial bus (SDA/SCL). It holds a channel-request mask and a connection override bit, and a simple register write port updates both. It samples each downstream bus's idle level through a two-flop synchronizer. When a connect request arrives, it decides which downstream channels join the upstream bus. While a link is up, it resolves the wired-AND level on SDA and on SCL and pulls low every participating line whenever any participant is low. The slave protocol engine, the analog buffers and the stuck-low timeout timer are outside this block. The timeout reaches the block only as a flag input.

Every bus-facing output is open-drain in form. A `*_pull` output at 1 means "drive the line low". At 0 it means high impedance. All `*_in` bus inputs give the level that external devices drive, not counting this block's own pull. A downstream channel reads as high when its synchronized SDA and SCL are both high.

A controller FSM has four states: `LK_OFF`, `LK_IDLE`, `LK_LINKED` and `LK_FAULT`.
- Gating (undervoltage or enable low) sends it to `LK_OFF` from any state. Ungated, `LK_OFF` goes to `LK_IDLE`.
- A granted connect write moves `LK_IDLE` (or `LK_OFF`, or `LK_FAULT`) to `LK_LINKED`.
- An empty grant moves `LK_LINKED` to `LK_IDLE`.
- A stuck flag moves `LK_LINKED` to `LK_FAULT`.
- The stuck flag clearing moves `LK_FAULT` to `LK_IDLE`.

Top module: `twl_link_ctrl`

## Requirements
- R1: The write port sets the override bit (address 1, bit 0) and the channel-request mask (address 2, bits 3:0). Reads return the following. Address 0 gives the stuck flag in bit 7 and the synchronized channel-high states in bits 3:0. Address 1 gives the override in bit 0. Address 2 gives the connected mask in bits 7:4 and the request mask in bits 3:0. Address 3 reads zero.
- R2: With the override clear, a connect write links only the requested channels whose synchronized state is high in the cycle of the write.
- R3: With the override set, a connect write links every requested channel whatever its state.
- R4: A connect write that grants no channel, or that arrives while the stuck flag is high, leaves every channel disconnected.
- R5: `ready_pull` is 0 exactly while a link is up; otherwise it is 1 (outside undervoltage).
- R6: While linked, each of SDA and SCL pulls low the upstream line and every connected downstream line when any of them is low. Unconnected channels are never pulled and never affect the level.
- R7: With `enable` low, the override, request and connected bits clear on the next edge, and writes are ignored.
- R8: `alert_pull` is 1 whenever any `alert_n_in` bit is 0, including while `enable` is low.
- R9: While `uvlo` is high, every pull output is 0 and the control bits clear.
- R10: A stuck flag during a link drops all channels and clears the request mask on the next edge. Channels stay dropped until a new connect write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo | input | 1 | Undervoltage lockout, high = locked out |
| enable | input | 1 | Block enable, low clears control bits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data |
| stuck_flag | input | 1 | Stuck-low timeout fault |
| up_sda_in | input | 1 | Upstream SDA level from external devices |
| up_scl_in | input | 1 | Upstream SCL level from external devices |
| ds_sda_in | input | 4 | Downstream SDA levels |
| ds_scl_in | input | 4 | Downstream SCL levels |
| alert_n_in | input | 4 | Downstream alert inputs, active low |
| up_sda_pull | output | 1 | Pull upstream SDA low |
| up_scl_pull | output | 1 | Pull upstream SCL low |
| ds_sda_pull | output | 4 | Pull downstream SDA low |
| ds_scl_pull | output | 4 | Pull downstream SCL low |
| ready_pull | output | 1 | Pull READY low (0 = released) |
| alert_pull | output | 1 | Pull ALERT low |

## Verification
The connection decision is tried with one channel held low (SCL low), so plain requests and override requests give different masks. It is also tried with all-zero requests and with requests made while the stuck flag is high. These cases separate the state filter, the override path and the blocking rules. The wired-AND is driven by a low on a connected channel, a low on an unconnected channel and a low upstream, which shows the connected set is exactly the one that takes part. Enable-low and undervoltage phases with alert inputs held low separate the alert path, which stays live, from the gated control path. A long run of random writes, levels and faults is then compared on every clock against a behavioural model.

// File: rtl/twl_pkg.sv
package twl_pkg;
    typedef enum logic [1:0] {
        LK_OFF    = 2'd0,
        LK_IDLE   = 2'd1,
        LK_LINKED = 2'd2,
        LK_FAULT  = 2'd3
    } link_st_t;

    localparam logic [1:0] ADDR_STAT = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_CONN = 2'd2;
endpackage

// File: rtl/twl_sync.sv
module twl_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/twl_cfg_regs.sv
module twl_cfg_regs
    import twl_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_off,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    input  logic [NCH-1:0]   req,
    input  logic [NCH-1:0]   act,
    input  logic [NCH-1:0]   ds_state,
    input  logic             stuck,
    output logic             ovr,
    output logic             conn_wr,
    output logic [NCH-1:0]   conn_data,
    output logic [REG_W-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr <= 1'b0;
        end else if (gate_off) begin
            ovr <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_CFG) begin
            ovr <= wr_data[0];
        end
    end

    assign conn_wr   = wr_en && !gate_off && (wr_addr == ADDR_CONN);
    assign conn_data = wr_data[NCH-1:0];

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_STAT: begin
                rd_data[REG_W-1] = stuck;
                rd_data[NCH-1:0] = ds_state;
            end
            ADDR_CFG: begin
                rd_data[0] = ovr;
            end
            ADDR_CONN: begin
                rd_data[NCH-1:0]     = req;
                rd_data[2*NCH-1:NCH] = act;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/twl_link_fsm.sv
module twl_link_fsm
    import twl_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           gate_off,
    input  logic           stuck,
    input  logic           conn_wr,
    input  logic [NCH-1:0] conn_data,
    input  logic           ovr,
    input  logic [NCH-1:0] ds_state,
    output logic [NCH-1:0] req,
    output logic [NCH-1:0] act,
    output logic           linked
);
    link_st_t       st_q, st_d;
    logic [NCH-1:0] req_d, act_d;
    logic [NCH-1:0] grant;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LK_OFF;
            req  <= '0;
            act  <= '0;
        end else begin
            st_q <= st_d;
            req  <= req_d;
            act  <= act_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        req_d = req;
        act_d = act;
        grant = conn_data & (ovr ? {NCH{1'b1}} : ds_state);
        if (gate_off) begin
            st_d  = LK_OFF;
            req_d = '0;
            act_d = '0;
        end else begin
            unique case (st_q)
                LK_OFF, LK_IDLE, LK_FAULT: begin
                    if (conn_wr) begin
                        req_d = conn_data;
                        if ((|grant) && !stuck) begin
                            st_d  = LK_LINKED;
                            act_d = grant;
                        end else begin
                            act_d = '0;
                            st_d  = (st_q == LK_FAULT && stuck) ? LK_FAULT : LK_IDLE;
                        end
                    end else if (st_q == LK_FAULT && !stuck) begin
                        st_d = LK_IDLE;
                    end else if (st_q == LK_OFF) begin
                        st_d = LK_IDLE;
                    end
                end
                LK_LINKED: begin
                    if (stuck) begin
                        st_d  = LK_FAULT;
                        req_d = '0;
                        act_d = '0;
                    end else if (conn_wr) begin
                        req_d = conn_data;
                        if (|grant) begin
                            act_d = grant;
                        end else begin
                            st_d  = LK_IDLE;
                            act_d = '0;
                        end
                    end
                end
            endcase
        end
    end

    assign linked = (st_q == LK_LINKED);
endmodule

// File: rtl/twl_wired_and.sv
module twl_wired_and #(
    parameter int NCH = 4
) (
    input  logic           linked,
    input  logic [NCH-1:0] act,
    input  logic           up_sda_in,
    input  logic           up_scl_in,
    input  logic [NCH-1:0] ds_sda_in,
    input  logic [NCH-1:0] ds_scl_in,
    output logic           up_sda_pull,
    output logic           up_scl_pull,
    output logic [NCH-1:0] ds_sda_pull,
    output logic [NCH-1:0] ds_scl_pull
);
    logic [NCH-1:0] sda_part, scl_part;
    logic           sda_lvl, scl_lvl;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign sda_part[i]    = ds_sda_in[i] | ~act[i];
            assign scl_part[i]    = ds_scl_in[i] | ~act[i];
            assign ds_sda_pull[i] = linked & act[i] & ~sda_lvl;
            assign ds_scl_pull[i] = linked & act[i] & ~scl_lvl;
        end
    endgenerate

    assign sda_lvl     = up_sda_in & (&sda_part);
    assign scl_lvl     = up_scl_in & (&scl_part);
    assign up_sda_pull = linked & ~sda_lvl;
    assign up_scl_pull = linked & ~scl_lvl;
endmodule

// File: rtl/twl_link_ctrl.sv
module twl_link_ctrl #(
    parameter int NCH   = 4,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uvlo,
    input  logic             enable,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             stuck_flag,
    input  logic             up_sda_in,
    input  logic             up_scl_in,
    input  logic [NCH-1:0]   ds_sda_in,
    input  logic [NCH-1:0]   ds_scl_in,
    input  logic [NCH-1:0]   alert_n_in,
    output logic             up_sda_pull,
    output logic             up_scl_pull,
    output logic [NCH-1:0]   ds_sda_pull,
    output logic [NCH-1:0]   ds_scl_pull,
    output logic             ready_pull,
    output logic             alert_pull
);
    logic           gate_off;
    logic [NCH-1:0] ds_state;
    logic           ovr, conn_wr, linked;
    logic [NCH-1:0] conn_data, req_mask, act_mask;
    logic           sda_pull_raw, scl_pull_raw;
    logic [NCH-1:0] ds_sda_raw, ds_scl_raw;

    assign gate_off = uvlo | ~enable;

    twl_sync #(.W(NCH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(ds_sda_in & ds_scl_in), .q(ds_state)
    );

    twl_cfg_regs #(.NCH(NCH), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .gate_off(gate_off),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .req(req_mask), .act(act_mask),
        .ds_state(ds_state), .stuck(stuck_flag),
        .ovr(ovr), .conn_wr(conn_wr), .conn_data(conn_data), .rd_data(rd_data)
    );

    twl_link_fsm #(.NCH(NCH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .gate_off(gate_off), .stuck(stuck_flag),
        .conn_wr(conn_wr), .conn_data(conn_data), .ovr(ovr),
        .ds_state(ds_state), .req(req_mask), .act(act_mask), .linked(linked)
    );

    twl_wired_and #(.NCH(NCH)) u_wand (
        .linked(linked), .act(act_mask),
        .up_sda_in(up_sda_in), .up_scl_in(up_scl_in),
        .ds_sda_in(ds_sda_in), .ds_scl_in(ds_scl_in),
        .up_sda_pull(sda_pull_raw), .up_scl_pull(scl_pull_raw),
        .ds_sda_pull(ds_sda_raw), .ds_scl_pull(ds_scl_raw)
    );

    assign up_sda_pull = sda_pull_raw & ~uvlo;
    assign up_scl_pull = scl_pull_raw & ~uvlo;
    assign ds_sda_pull = ds_sda_raw & {NCH{~uvlo}};
    assign ds_scl_pull = ds_scl_raw & {NCH{~uvlo}};
    assign ready_pull  = ~uvlo & ~linked;
    assign alert_pull  = ~uvlo & ~(&alert_n_in);
endmodule

// File: rtl/twl_link_ctrl_chk.sv
module twl_link_ctrl_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           uvlo,
    input logic           enable,
    input logic           stuck_flag,
    input logic [NCH-1:0] alert_n_in,
    input logic           up_sda_pull,
    input logic           up_scl_pull,
    input logic [NCH-1:0] ds_sda_pull,
    input logic [NCH-1:0] ds_scl_pull,
    input logic           ready_pull,
    input logic           alert_pull,
    input logic [NCH-1:0] act_mask
);
    // R9
    uvlo_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |-> (!ready_pull && !alert_pull && !up_sda_pull && !up_scl_pull
                  && ds_sda_pull == '0 && ds_scl_pull == '0));

    // R8
    alert_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!uvlo && !(&alert_n_in)) |-> alert_pull);

    // R7
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (act_mask == '0));

    // R10
    stuck_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stuck_flag && enable && !uvlo) |=> (ready_pull || uvlo));

    // R5
    ready_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!uvlo && !ready_pull) |-> (act_mask != '0));

    // R6
    pull_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ds_sda_pull & ~act_mask) == '0) && ((ds_scl_pull & ~act_mask) == '0));
endmodule

bind twl_link_ctrl twl_link_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .enable(enable),
    .stuck_flag(stuck_flag), .alert_n_in(alert_n_in),
    .up_sda_pull(up_sda_pull), .up_scl_pull(up_scl_pull),
    .ds_sda_pull(ds_sda_pull), .ds_scl_pull(ds_scl_pull),
    .ready_pull(ready_pull), .alert_pull(alert_pull), .act_mask(act_mask)
);

// File: tb/sim_twl_link_ctrl.sv
`timescale 1ns/1ps
module sim_twl_link_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uvlo = 1'b0, enable = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       stuck_flag = 1'b0;
    logic       up_sda_in = 1'b1, up_scl_in = 1'b1;
    logic [3:0] ds_sda_in = 4'hF, ds_scl_in = 4'hF, alert_n_in = 4'hF;
    logic       up_sda_pull, up_scl_pull, ready_pull, alert_pull;
    logic [3:0] ds_sda_pull, ds_scl_pull;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural reference state: 0 off, 1 idle, 2 linked, 3 fault
    int         m_st = 0;
    logic [3:0] m_req = 0, m_act = 0, m_s1 = 0, m_s2 = 0;
    logic       m_ovr = 0;

    always #10 clk = ~clk;

    twl_link_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .enable(enable),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .stuck_flag(stuck_flag),
        .up_sda_in(up_sda_in), .up_scl_in(up_scl_in),
        .ds_sda_in(ds_sda_in), .ds_scl_in(ds_scl_in), .alert_n_in(alert_n_in),
        .up_sda_pull(up_sda_pull), .up_scl_pull(up_scl_pull),
        .ds_sda_pull(ds_sda_pull), .ds_scl_pull(ds_scl_pull),
        .ready_pull(ready_pull), .alert_pull(alert_pull)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic sl, cl;
        logic [3:0] es, ec;
        logic [7:0] erd;
        bit lk;
        lk = (m_st == 2) && !uvlo;
        sl = up_sda_in; cl = up_scl_in;
        for (int i = 0; i < 4; i++) begin
            if (m_act[i]) begin
                sl = sl & ds_sda_in[i];
                cl = cl & ds_scl_in[i];
            end
        end
        es = (lk && !sl) ? m_act : 4'h0;
        ec = (lk && !cl) ? m_act : 4'h0;
        case (rd_addr)
            2'd0: erd = {stuck_flag, 3'b000, m_s2};
            2'd1: erd = {7'd0, m_ovr};
            2'd2: erd = {m_act, m_req};
            default: erd = 8'h00;
        endcase
        chk("R5 ready", {7'd0, ready_pull}, {7'd0, !uvlo && m_st != 2});
        chk("R8 alert", {7'd0, alert_pull}, {7'd0, !uvlo && alert_n_in != 4'hF});
        chk("R6 up sda", {7'd0, up_sda_pull}, {7'd0, lk && !sl});
        chk("R6 up scl", {7'd0, up_scl_pull}, {7'd0, lk && !cl});
        chk("R6 ds sda", {4'd0, ds_sda_pull}, {4'd0, es});
        chk("R6 ds scl", {4'd0, ds_scl_pull}, {4'd0, ec});
        chk("R1 readback", rd_data, erd);
    endtask

    task automatic model_edge();
        bit gate, cw;
        logic [3:0] g, d;
        if (!rst_n) begin
            m_st = 0; m_req = 0; m_act = 0; m_ovr = 0; m_s1 = 0; m_s2 = 0;
            return;
        end
        gate = uvlo || !enable;
        d = wr_data[3:0];
        cw = wr_en && wr_addr == 2'd2 && !gate;
        g = d & (m_ovr ? 4'hF : m_s2);
        if (gate) begin
            m_st = 0; m_req = 0; m_act = 0;
        end else if (m_st == 2) begin
            if (stuck_flag) begin
                m_st = 3; m_req = 0; m_act = 0;
            end else if (cw) begin
                m_req = d;
                if (g != 0) m_act = g;
                else begin m_st = 1; m_act = 0; end
            end
        end else begin
            if (cw) begin
                m_req = d;
                if (g != 0 && !stuck_flag) begin m_st = 2; m_act = g; end
                else begin
                    m_act = 0;
                    m_st = (m_st == 3 && stuck_flag) ? 3 : 1;
                end
            end else if (m_st == 3 && !stuck_flag) m_st = 1;
            else if (m_st == 0) m_st = 1;
        end
        if (gate) m_ovr = 0;
        else if (wr_en && wr_addr == 2'd1) m_ovr = wr_data[0];
        m_s2 = m_s1;
        m_s1 = ds_sda_in & ds_scl_in;
    endtask

    task automatic tick();
        #1 compare_all();
        model_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic expect_rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1 chk(tag, rd_data, exp);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) tick();
        expect_rd("R1 reset conn", 2'd2, 8'h00);
        chk("R5 reset ready", {7'd0, ready_pull}, 8'h01);
        rst_n = 1'b1; enable = 1'b1;
        ds_scl_in = 4'b1101;
        for (int i = 0; i < 4; i++) tick();
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h03);
        expect_rd("R2 only high channel linked", 2'd2, 8'h13);
        chk("R5 released when linked", {7'd0, ready_pull}, 8'h00);
        ds_sda_in[2] = 1'b0;
        #1 chk("R6 unconnected low ignored", {7'd0, up_sda_pull}, 8'h00);
        ds_sda_in[0] = 1'b0;
        #1 chk("R6 connected low pulls up", {7'd0, up_sda_pull}, 8'h01);
        chk("R6 connected low pulls ds", {4'd0, ds_sda_pull}, 8'h01);
        ds_sda_in = 4'hF;
        up_scl_in = 1'b0;
        #1 chk("R6 upstream low pulls ds scl", {4'd0, ds_scl_pull}, 8'h01);
        up_scl_in = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        wr(2'd1, 8'h01);
        wr(2'd2, 8'h06);
        expect_rd("R3 override links low channel", 2'd2, 8'h66);
        stuck_flag = 1'b1;
        tick();
        expect_rd("R10 stuck drops link", 2'd2, 8'h00);
        chk("R10 ready low on fault", {7'd0, ready_pull}, 8'h01);
        wr(2'd2, 8'h0F);
        expect_rd("R4 stuck blocks connect", 2'd2, 8'h0F);
        stuck_flag = 1'b0;
        tick();
        wr(2'd2, 8'h00);
        expect_rd("R4 empty request no link", 2'd2, 8'h00);
        wr(2'd2, 8'h0F);
        expect_rd("R10 rewrite relinks", 2'd2, 8'hFF);
        enable = 1'b0;
        tick();
        expect_rd("R7 disable clears conn", 2'd2, 8'h00);
        expect_rd("R7 disable clears override", 2'd1, 8'h00);
        wr(2'd1, 8'h01);
        expect_rd("R7 write ignored when disabled", 2'd1, 8'h00);
        alert_n_in = 4'b0111;
        #1 chk("R8 alert while disabled", {7'd0, alert_pull}, 8'h01);
        alert_n_in = 4'hF;
        #1 chk("R8 alert released", {7'd0, alert_pull}, 8'h00);
        enable = 1'b1;
        tick();
        wr(2'd1, 8'h01);
        wr(2'd2, 8'h0F);
        uvlo = 1'b1; alert_n_in = 4'h0; up_sda_in = 1'b0;
        #1 chk("R9 ready hiz", {7'd0, ready_pull}, 8'h00);
        chk("R9 alert hiz", {7'd0, alert_pull}, 8'h00);
        chk("R9 bus hiz", {7'd0, up_sda_pull}, 8'h00);
        tick();
        wr(2'd1, 8'h01);
        uvlo = 1'b0; alert_n_in = 4'hF; up_sda_in = 1'b1;
        expect_rd("R9 bits cleared under lockout", 2'd1, 8'h00);
        tick();
        for (int n = 0; n < 600; n++) begin
            wr_en      = ($urandom_range(0, 3) == 0);
            wr_addr    = 2'($urandom_range(0, 3));
            wr_data    = 8'($urandom);
            rd_addr    = 2'($urandom_range(0, 3));
            stuck_flag = ($urandom_range(0, 15) == 0);
            enable     = ($urandom_range(0, 31) != 0);
            uvlo       = ($urandom_range(0, 63) == 0);
            ds_sda_in  = 4'($urandom) | 4'($urandom);
            ds_scl_in  = 4'($urandom) | 4'($urandom);
            up_sda_in  = ($urandom_range(0, 3) != 0);
            up_scl_in  = ($urandom_range(0, 3) != 0);
            alert_n_in = 4'($urandom) | 4'($urandom) | 4'($urandom);
            tick();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule